// File: doc/BRIEF.md
# Flag-Counting HDLC Frame Receiver

This block takes a bit-serial HDLC line, one bit per rising edge of the receive bit clock, and extracts frames from it. It hunts for the 0x7E flag pattern. It opens a frame only after a configured number of back-to-back flags has been seen. It then strips the zeros that the transmitter inserted after runs of five ones, packs the surviving bits into bytes and pushes each byte out on a FIFO write port.

The end of the payload is a flag that lands on a byte boundary. The block then counts further flags that follow at 8-bit spacing. When the configured closing count is reached, it pulses `frameGood`. A short closing run, a flag that cuts a byte in half, or a run of seven ones makes it pulse `frameError` instead. The host then discards every byte written since the frame opened, and `frameBytes` tells it how many that is. CRC checking and field parsing are left to whatever reads the FIFO.

Top module: `hdlc_flag_rx`

## Requirements
- R1: `rxBit` is sampled on the rising edge of `clk`, and bytes are assembled least significant bit first. Each completed byte appears on `fifoWrData` with `fifoWrEn` high for exactly one cycle, in the cycle after the edge that sampled its last bit. `frameBytes` counts the bytes written for the current frame.
- R2: A frame opens only after `cfgOpenFlags` consecutive flags have been seen. Flags are the raw bit sequence 0,1,1,1,1,1,1,0 in arrival order (0x7E), and consecutive flags sit exactly 8 bits apart. With fewer flags than that, no byte is written and no status pulse occurs. A configured value of 0 behaves as 1.
- R3: Extra flags that arrive after the frame opened, but before its first byte completed, are idle fill and produce no bytes.
- R4: Inside a frame, a 0 that follows five consecutive 1s is removed and never reaches a byte.
- R5: A flag whose last bit completes a byte boundary ends the payload and counts as the first closing flag. When `cfgCloseFlags` consecutive closing flags have been counted, `frameGood` pulses for one cycle. While it is high, `frameBytes` equals the number of payload bytes. A value of 0 behaves as 1.
- R6: If the 8 bits after a closing flag are not a flag before the closing count is reached, `frameError` pulses for one cycle and the frame is to be discarded.
- R7: Seven consecutive 1s inside an open frame abort it: `frameError` pulses and the receiver returns to hunting.
- R8: A flag that arrives while a partial byte (1 to 7 destuffed bits) is pending ends the frame with a `frameError` pulse.
- R9: After any good or error decision the opening-flag count restarts from zero. Closing flags of one frame do not count toward opening the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxBit | input | 1 | Serial line data |
| cfgOpenFlags | input | CNT_W | Number of consecutive flags required to open a frame |
| cfgCloseFlags | input | CNT_W | Number of consecutive flags required to accept a frame |
| fifoWrEn | output | 1 | One-cycle write strobe for a received byte |
| fifoWrData | output | 8 | Received byte |
| frameGood | output | 1 | One-cycle pulse: frame accepted |
| frameError | output | 1 | One-cycle pulse: frame discarded |
| frameBytes | output | BYTE_CNT_W | Bytes written for the current or last frame |

## Verification
The assertions take for granted that `rxBit` changes only away from the rising clock edge. They also assume the two flag-count settings stay still while a frame is open, so that a decision pulse never meets a byte write and pulses stay one cycle wide. The stimulus drives every line bit on the falling edge. It changes the configuration only after a stretch of idle ones, which resets the flag hunt. It also limits how many surplus closing flags it sends to fewer than the opening count, so surplus flags cannot open a new frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [7:0] FLAG_PATTERN = 8'h7E;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CLOSE = 2'd2
  } rxState_t;

  // control -> datapath
  typedef struct packed {
    logic capture;   // push destuffed bits into the byte assembler
    logic realign;   // restart the byte phase (idle fill flag)
    logic newFrame;  // clear byte phase and byte count
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic flagHit;      // current bit completes 0x7E
    logic stuffHit;     // current bit is an inserted zero
    logic abortHit;     // current bit is the seventh 1 in a row
    logic byteAligned;  // seven bits pending: a flag now sits on a boundary
    logic noBytes;      // no byte written yet in this frame
  } dpStatus_t;

endpackage

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rxBit,
  input  dpStrobe_t             strobe,
  output dpStatus_t             status,
  output logic                  fifoWrEn,
  output logic [7:0]            fifoWrData,
  output logic [BYTE_CNT_W-1:0] frameBytes
);

  localparam logic [BYTE_CNT_W-1:0] BYTE_ONE = 1;
  localparam logic [2:0] ONES_SAT = 3'd7;

  logic [7:0] flagSr;
  logic [7:0] flagNext;
  logic [2:0] onesCnt;
  logic [7:0] dataSr;
  logic [7:0] dataNext;
  logic [2:0] bitCnt;
  logic [BYTE_CNT_W-1:0] byteCnt;
  logic pushBit;

  assign flagNext = {rxBit, flagSr[7:1]};
  assign dataNext = {rxBit, dataSr[7:1]};

  always_comb begin
    status.flagHit     = (flagNext == FLAG_PATTERN);
    status.stuffHit    = !rxBit && (onesCnt == 3'd5);
    status.abortHit    = rxBit && (onesCnt >= 3'd6);
    status.byteAligned = (bitCnt == 3'd7);
    status.noBytes     = (byteCnt == '0);
  end

  assign pushBit = strobe.capture && !status.stuffHit &&
                   !status.flagHit && !status.abortHit;

  // raw line history: flag window and run-of-ones counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagSr  <= '0;
      onesCnt <= '0;
    end else begin
      flagSr <= flagNext;
      if (!rxBit)
        onesCnt <= '0;
      else if (onesCnt != ONES_SAT)
        onesCnt <= onesCnt + 3'd1;
    end
  end

  // byte assembler and FIFO write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataSr     <= '0;
      bitCnt     <= '0;
      byteCnt    <= '0;
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else begin
      fifoWrEn <= 1'b0;
      if (strobe.newFrame) begin
        bitCnt  <= '0;
        byteCnt <= '0;
      end else if (strobe.realign) begin
        bitCnt <= '0;
      end else if (pushBit) begin
        dataSr <= dataNext;
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          fifoWrEn   <= 1'b1;
          fifoWrData <= dataNext;
          byteCnt    <= byteCnt + BYTE_ONE;
        end
      end
    end
  end

  assign frameBytes = byteCnt;

endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfgOpenFlags,
  input  logic [CNT_W-1:0] cfgCloseFlags,
  input  dpStatus_t        status,
  output dpStrobe_t        strobe,
  output logic             frameGood,
  output logic             frameError
);

  localparam logic [CNT_W:0] CNT_ONE = 1;

  rxState_t         state, stateN;
  logic [CNT_W-1:0] flagCnt, flagCntN;
  logic [2:0]       phase, phaseN;
  logic             goodN, errN;
  logic [CNT_W:0]   openTarget, closeTarget, bumped;

  assign openTarget  = (cfgOpenFlags  == '0) ? CNT_ONE : {1'b0, cfgOpenFlags};
  assign closeTarget = (cfgCloseFlags == '0) ? CNT_ONE : {1'b0, cfgCloseFlags};
  assign bumped      = {1'b0, flagCnt} + CNT_ONE;

  always_comb begin
    stateN   = state;
    flagCntN = flagCnt;
    phaseN   = phase + 3'd1;
    goodN    = 1'b0;
    errN     = 1'b0;
    strobe   = '0;
    unique case (state)
      ST_HUNT: begin
        if (flagCnt == '0) begin
          if (status.flagHit) begin
            phaseN = '0;
            if (openTarget == CNT_ONE) begin
              stateN          = ST_DATA;
              strobe.newFrame = 1'b1;
            end else begin
              flagCntN = CNT_ONE[CNT_W-1:0];
            end
          end
        end else if (phase == 3'd7) begin
          if (status.flagHit) begin
            if (bumped >= openTarget) begin
              stateN          = ST_DATA;
              flagCntN        = '0;
              strobe.newFrame = 1'b1;
            end else begin
              flagCntN = bumped[CNT_W-1:0];
            end
          end else begin
            flagCntN = '0;
          end
        end
      end
      ST_DATA: begin
        strobe.capture = 1'b1;
        if (status.abortHit) begin
          errN   = 1'b1;
          stateN = ST_HUNT;
        end else if (status.flagHit) begin
          if (status.noBytes) begin
            strobe.realign = 1'b1;
          end else if (status.byteAligned) begin
            phaseN = '0;
            if (closeTarget == CNT_ONE) begin
              goodN  = 1'b1;
              stateN = ST_HUNT;
            end else begin
              stateN   = ST_CLOSE;
              flagCntN = CNT_ONE[CNT_W-1:0];
            end
          end else begin
            errN   = 1'b1;
            stateN = ST_HUNT;
          end
        end
      end
      ST_CLOSE: begin
        if (phase == 3'd7) begin
          stateN   = ST_HUNT;
          flagCntN = '0;
          if (!status.flagHit) begin
            errN = 1'b1;
          end else if (bumped >= closeTarget) begin
            goodN = 1'b1;
          end else begin
            stateN   = ST_CLOSE;
            flagCntN = bumped[CNT_W-1:0];
          end
        end
      end
      default: begin
        stateN   = ST_HUNT;
        flagCntN = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      flagCnt    <= '0;
      phase      <= '0;
      frameGood  <= 1'b0;
      frameError <= 1'b0;
    end else begin
      state      <= stateN;
      flagCnt    <= flagCntN;
      phase      <= phaseN;
      frameGood  <= goodN;
      frameError <= errN;
    end
  end

endmodule

// File: rtl/hdlc_flag_rx.sv
module hdlc_flag_rx
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int BYTE_CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rxBit,
  input  logic [CNT_W-1:0]      cfgOpenFlags,
  input  logic [CNT_W-1:0]      cfgCloseFlags,
  output logic                  fifoWrEn,
  output logic [7:0]            fifoWrData,
  output logic                  frameGood,
  output logic                  frameError,
  output logic [BYTE_CNT_W-1:0] frameBytes
);

  dpStrobe_t strobe;
  dpStatus_t status;

  hdlc_rx_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgOpenFlags (cfgOpenFlags),
    .cfgCloseFlags(cfgCloseFlags),
    .status       (status),
    .strobe       (strobe),
    .frameGood    (frameGood),
    .frameError   (frameError)
  );

  hdlc_rx_datapath #(.BYTE_CNT_W(BYTE_CNT_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxBit     (rxBit),
    .strobe    (strobe),
    .status    (status),
    .fifoWrEn  (fifoWrEn),
    .fifoWrData(fifoWrData),
    .frameBytes(frameBytes)
  );

endmodule

// File: rtl/hdlc_flag_rx_sva.sv
module hdlc_flag_rx_sva #(
  parameter int BYTE_CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rxBit,
  input logic                  fifoWrEn,
  input logic                  frameGood,
  input logic                  frameError,
  input logic [BYTE_CNT_W-1:0] frameBytes
);

  logic [7:0] lineHist;
  logic       flagSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineHist <= '0;
      flagSeen <= 1'b0;
    end else begin
      lineHist <= {rxBit, lineHist[7:1]};
      if ({rxBit, lineHist[7:1]} == 8'h7E)
        flagSeen <= 1'b1;
    end
  end

  a_r1_count_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    fifoWrEn |-> frameBytes == BYTE_CNT_W'($past(frameBytes) + 1'b1));

  a_r1_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fifoWrEn |=> !fifoWrEn);

  a_r2_write_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fifoWrEn |-> flagSeen);

  a_r5_good_alone: assert property (@(posedge clk) disable iff (!rst_n)
    frameGood |-> (!fifoWrEn && !frameError));

  a_r5_good_single: assert property (@(posedge clk) disable iff (!rst_n)
    frameGood |=> !frameGood);

  a_r6_error_single: assert property (@(posedge clk) disable iff (!rst_n)
    frameError |=> !frameError);

endmodule

bind hdlc_flag_rx hdlc_flag_rx_sva #(.BYTE_CNT_W(BYTE_CNT_W)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rxBit     (rxBit),
  .fifoWrEn  (fifoWrEn),
  .frameGood (frameGood),
  .frameError(frameError),
  .frameBytes(frameBytes)
);

// File: tb/hdlc_flag_rx_tb_top.sv
module hdlc_flag_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxBit = 1'b1;
  logic [3:0]  cfgOpenFlags = 4'd1;
  logic [3:0]  cfgCloseFlags = 4'd1;
  logic        fifoWrEn;
  logic [7:0]  fifoWrData;
  logic        frameGood;
  logic        frameError;
  logic [15:0] frameBytes;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hdlc_flag_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxBit(rxBit),
    .cfgOpenFlags(cfgOpenFlags), .cfgCloseFlags(cfgCloseFlags),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .frameGood(frameGood), .frameError(frameError), .frameBytes(frameBytes)
  );

  // observation, sampled 1 ns after each rising edge
  logic [7:0] gotBytes [0:15];
  int gotN = 0, goodN = 0, errN = 0, goodLen = -1;

  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (fifoWrEn) begin
        if (gotN < 16) gotBytes[gotN] = fifoWrData;
        gotN++;
      end
      if (frameGood) begin
        goodN++;
        goodLen = int'(frameBytes);
      end
      if (frameError) errN++;
    end
  end

  task automatic clearObs();
    gotN = 0; goodN = 0; errN = 0; goodLen = -1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // transmitter model
  int txOnes = 0;
  localparam logic [7:0] FLAG = 8'h7E;

  task automatic txRaw(input logic b);
    @(negedge clk);
    rxBit = b;
  endtask

  task automatic txFlag();
    for (int i = 0; i < 8; i++) txRaw(FLAG[i]);
    txOnes = 0;
  endtask

  task automatic txData(input logic b);
    txRaw(b);
    if (b) begin
      txOnes++;
      if (txOnes == 5) begin
        txRaw(1'b0);
        txOnes = 0;
      end
    end else begin
      txOnes = 0;
    end
  endtask

  task automatic txByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) txData(v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) txRaw(1'b1);
    txOnes = 0;
  endtask

  function automatic logic [7:0] payload(input int seed, input int i);
    int sel;
    sel = (seed + i) % 5;
    case (sel)
      0: return 8'hFF;
      1: return 8'h7E;
      2: return 8'h3E;
      3: return 8'(seed * 37 + i * 91 + 5);
      default: return 8'hF8;
    endcase
  endfunction

  task automatic runFrame(input int cO, input int cC, input int nOpen,
                          input int len, input int nClose, input int seed);
    int eo, ec;
    eo = (cO == 0) ? 1 : cO;
    ec = (cC == 0) ? 1 : cC;
    cfgOpenFlags  = 4'(cO);
    cfgCloseFlags = 4'(cC);
    clearObs();
    for (int i = 0; i < nOpen; i++) txFlag();
    for (int i = 0; i < len; i++) txByte(payload(seed, i));
    for (int i = 0; i < nClose; i++) txFlag();
    idle(10);
    @(negedge clk);
    @(negedge clk);
    if (nOpen < eo) begin
      check(gotN == 0, "R2", "writes with too few opening flags", gotN, 0);
      check(goodN == 0 && errN == 0, "R2", "pulses with too few opening flags",
            goodN + errN, 0);
    end else begin
      check(gotN == len, "R1", "bytes written", gotN, len);
      for (int i = 0; i < len && i < gotN; i++)
        check(gotBytes[i] == payload(seed, i), "R4", "destuffed byte value",
              int'(gotBytes[i]), int'(payload(seed, i)));
      if (nClose == 0) begin
        check(errN == 1 && goodN == 0, "R7", "abort error pulses", errN, 1);
      end else if (nClose < ec) begin
        check(errN == 1 && goodN == 0, "R6", "short closing error pulses", errN, 1);
      end else begin
        check(goodN == 1 && errN == 0, "R5", "good pulses", goodN, 1);
        check(goodLen == len, "R5", "frameBytes at good", goodLen, len);
        if (nOpen > eo)
          check(gotN == len, "R3", "fill flags add no bytes", gotN, len);
        if (nClose > ec)
          check(errN == 0, "R9", "surplus closing flags open nothing", errN, 0);
      end
    end
  endtask

  initial begin : main
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    #1;
    check(fifoWrEn == 1'b0, "R1", "reset fifoWrEn", int'(fifoWrEn), 0);
    check(frameGood == 1'b0 && frameError == 1'b0, "R5", "reset pulses",
          int'(frameGood) + int'(frameError), 0);
    check(frameBytes == 16'd0, "R1", "reset frameBytes", int'(frameBytes), 0);
    rst_n = 1'b1;
    idle(12);

    for (int cO = 1; cO <= 3; cO++)
      for (int cC = 1; cC <= 3; cC++)
        for (int nO = 1; nO <= 4; nO++)
          for (int nC = 0; nC <= 4; nC++) begin
            if (nO < cO && nC >= cO) continue;
            if (nC - cC >= cO) continue;
            runFrame(cO, cC, nO, 1 + (seed % 3), nC, seed);
            seed++;
          end

    // zero settings behave as one (R2, R5)
    runFrame(0, 0, 1, 2, 1, 7);

    // R8: flag after a partial byte
    cfgOpenFlags = 4'd1; cfgCloseFlags = 4'd1;
    clearObs();
    txFlag();
    txByte(8'hA5); txByte(8'h5A);
    txData(1'b1); txData(1'b0); txData(1'b1);
    txFlag();
    idle(10);
    @(negedge clk); @(negedge clk);
    check(errN == 1, "R8", "partial byte error pulses", errN, 1);
    check(goodN == 0, "R8", "partial byte good pulses", goodN, 0);

    // R7: explicit abort in mid-byte
    clearObs();
    txFlag(); txFlag();
    txByte(8'h81);
    txData(1'b0);
    for (int i = 0; i < 8; i++) txRaw(1'b1);
    idle(4);
    @(negedge clk); @(negedge clk);
    check(errN == 1 && goodN == 0, "R7", "mid-byte abort", errN, 1);
    check(gotN == 1, "R7", "bytes before abort", gotN, 1);

    // R9: closing flags do not reopen; a following frame needs its own opener
    cfgOpenFlags = 4'd2; cfgCloseFlags = 4'd1;
    clearObs();
    txFlag(); txFlag(); txByte(8'h11); txFlag(); txFlag();
    txByte(8'h22); txByte(8'h33);
    idle(10);
    @(negedge clk); @(negedge clk);
    check(goodN == 1 && errN == 0, "R9", "only first frame accepted", goodN, 1);
    check(gotN == 1, "R9", "no bytes from unopened data", gotN, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule